// File: doc/BRIEF.md
# Event-Boundary and Error Action Controller

This block is the central sequencer of a pattern-matching track-trigger board. Two upstream processing units, a hit unit and a road unit, each send an end-of-event strobe when they finish an event. The controller issues an event-initialisation pulse when both strobes for an event have arrived, and it sends one such pulse after reset to open the first event. It counts the events that have been opened but not yet fully processed. A separate `evt_done_i` strobe retires the oldest open event.

The controller also receives error reports. Each report carries a kind code and a mask of faulty streams. A 16-bit severity map, indexed by kind, picks one of two actions for each report. The first action drops the named streams quietly by ORing them into a sticky removal mask. The second action freezes the system. A freeze does not take effect at once: it waits until every event that was open when the error arrived has drained. It then raises a broadcast freeze for the sibling FPGAs and an upstream freeze together. A software clear strobe returns the freeze state and the removal mask to idle.

Top module: `evt_err_ctrl`

## Requirements
- R1: In the first cycle after reset is released, `init_evt_o` is high for exactly one cycle. During and right after reset, both freeze outputs are low and `removed_o` is zero.
- R2: `init_evt_o` pulses for one cycle in the cycle after both `hit_eoe_i` and `road_eoe_i` have been seen since the last pairing. The two strobes may come in either order or in the same cycle. Extra strobes from one unit before the other unit's strobe count once.
- R3: An error report is `err_kind_i` (4 bits) and `err_streams_i` (8 bits, where bit i names stream i), qualified by `err_valid_i`. Bit k of `sev_map_i` equal to 1 makes kind k a freeze error. A 0 makes it a removal error, and a freeze error never changes `removed_o`.
- R4: A removal error ORs its stream mask into `removed_o`, visible in the next cycle. The bits stay set.
- R5: On a freeze error, let N be the open-event count (pulses of `init_evt_o` so far, minus `evt_done_i` strobes that found an open event) less one if `evt_done_i` is in the same cycle. If N is 0, freeze rises in the next cycle. Otherwise it rises in the cycle after the N-th later `evt_done_i`.
- R6: `freeze_bcast_o` and `freeze_up_o` rise together and stay high until `sw_clear_i`.
- R7: While frozen, error reports of both kinds are ignored.
- R8: A freeze error that arrives while a freeze is already waiting neither restarts nor extends the wait. Removal errors during the wait still apply.
- R9: `sw_clear_i` clears the freeze, any waiting freeze and `removed_o` in the next cycle. It takes priority over an error in the same cycle.
- R10: An `evt_done_i` strobe when no event is open has no effect. The open-event count saturates at 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_eoe_i | input | 1 | End-of-event strobe from the hit unit |
| road_eoe_i | input | 1 | End-of-event strobe from the road unit |
| evt_done_i | input | 1 | Oldest open event fully processed |
| err_valid_i | input | 1 | Error report valid |
| err_kind_i | input | 4 | Error kind code |
| err_streams_i | input | 8 | Faulty stream mask |
| sev_map_i | input | 16 | Per-kind action map, 1 = freeze |
| sw_clear_i | input | 1 | Software clear of freeze and removal mask |
| init_evt_o | output | 1 | Event-initialisation pulse |
| freeze_bcast_o | output | 1 | Freeze to all board FPGAs |
| freeze_up_o | output | 1 | Freeze sent upstream |
| removed_o | output | 8 | Sticky removed-streams mask |

## Verification
Every output is registered once. The init pulse, a removal, a clear and a freeze with no open event all appear one cycle after the input edge that causes them. A freeze that must wait appears one cycle after the `evt_done_i` that retires the last event it waits for. The reference model applies the same sampling edge and compares all outputs one nanosecond after every rising edge. The directed checks pulse an input for one cycle and read the outputs at the next falling edge, which is the first point where the result is visible.

// File: rtl/eec_pkg.sv
`timescale 1ns/1ps
package eec_pkg;
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_REMOVE = 2'd1,
        ACT_FREEZE = 2'd2
    } err_act_e;
endpackage

// File: rtl/eec_boundary.sv
`timescale 1ns/1ps
module eec_boundary #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_eoe_i,
    input  logic             road_eoe_i,
    input  logic             evt_done_i,
    output logic             init_o,
    output logic [CNT_W-1:0] open_cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             start;
        logic             hit_seen;
        logic             road_seen;
        logic             init;
        logic [CNT_W-1:0] open_cnt;
    } bnd_st_t;

    bnd_st_t st_q, st_d;
    logic    pair_done;
    logic    close_evt;

    always_comb begin
        st_d      = st_q;
        pair_done = (st_q.hit_seen | hit_eoe_i) & (st_q.road_seen | road_eoe_i);
        close_evt = evt_done_i && (st_q.open_cnt != '0);
        st_d.start = 1'b0;
        st_d.init  = st_q.start | pair_done;
        if (pair_done) begin
            st_d.hit_seen  = 1'b0;
            st_d.road_seen = 1'b0;
        end else begin
            st_d.hit_seen  = st_q.hit_seen | hit_eoe_i;
            st_d.road_seen = st_q.road_seen | road_eoe_i;
        end
        st_d.open_cnt = st_q.open_cnt - CNT_W'(close_evt);
        if (st_d.init && (st_d.open_cnt != CNT_MAX)) begin
            st_d.open_cnt = st_d.open_cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.start    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign init_o     = st_q.init;
    assign open_cnt_o = st_q.open_cnt;

    // R2
    pair_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.hit_seen && st_q.road_seen));

    // R1
    start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.start |=> !st_q.start);

    // R10
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.open_cnt == '0) && !st_q.init |=> (st_q.open_cnt == '0) || st_q.init);
endmodule

// File: rtl/eec_classify.sv
`timescale 1ns/1ps
module eec_classify
    import eec_pkg::*;
#(
    parameter int KIND_W = 4,
    parameter int NSTR   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 err_valid_i,
    input  logic [KIND_W-1:0]    err_kind_i,
    input  logic [NSTR-1:0]      err_streams_i,
    input  logic [(1<<KIND_W)-1:0] sev_map_i,
    input  logic                 frozen_i,
    input  logic                 sw_clear_i,
    output err_act_e             act_o,
    output logic [NSTR-1:0]      removed_o
);
    localparam int NKIND = 1 << KIND_W;

    typedef struct packed {
        logic [NSTR-1:0] removed;
    } cls_st_t;

    cls_st_t           st_q, st_d;
    err_act_e          act;
    logic [NKIND-1:0]  kind_hot;
    logic              is_freeze;

    for (genvar k = 0; k < NKIND; k++) begin : g_kind
        assign kind_hot[k] = (err_kind_i == KIND_W'(k)) && sev_map_i[k];
    end

    assign is_freeze = |kind_hot;

    always_comb begin
        st_d = st_q;
        act  = ACT_NONE;
        if (err_valid_i && !frozen_i && !sw_clear_i) begin
            act = is_freeze ? ACT_FREEZE : ACT_REMOVE;
        end
        if (sw_clear_i) begin
            st_d.removed = '0;
        end else if (act == ACT_REMOVE) begin
            st_d.removed = st_q.removed | err_streams_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o     = act;
    assign removed_o = st_q.removed;

    // R4
    mask_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_clear_i |=> ((st_q.removed & $past(st_q.removed)) == $past(st_q.removed)));

    // R7
    frozen_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frozen_i && !sw_clear_i |=> $stable(st_q.removed));

    // R9
    clear_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clear_i |=> (st_q.removed == '0));
endmodule

// File: rtl/eec_freeze.sv
`timescale 1ns/1ps
module eec_freeze #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_freeze_i,
    input  logic [CNT_W-1:0] open_cnt_i,
    input  logic             evt_done_i,
    input  logic             sw_clear_i,
    output logic             frozen_o,
    output logic             pending_o
);
    typedef struct packed {
        logic             frozen;
        logic             pending;
        logic [CNT_W-1:0] drain;
    } frz_st_t;

    frz_st_t          st_q, st_d;
    logic             close_evt;
    logic [CNT_W-1:0] remain;

    always_comb begin
        st_d      = st_q;
        close_evt = evt_done_i && (open_cnt_i != '0);
        remain    = open_cnt_i - CNT_W'(close_evt);
        if (sw_clear_i) begin
            st_d = '0;
        end else if (st_q.pending) begin
            if (close_evt) begin
                st_d.drain = st_q.drain - CNT_W'(1);
                if (st_q.drain == CNT_W'(1)) begin
                    st_d.pending = 1'b0;
                    st_d.frozen  = 1'b1;
                end
            end
        end else if (act_freeze_i) begin
            if (remain == '0) begin
                st_d.frozen = 1'b1;
            end else begin
                st_d.pending = 1'b1;
                st_d.drain   = remain;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frozen_o  = st_q.frozen;
    assign pending_o = st_q.pending;

    // R6
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.frozen && !sw_clear_i |=> st_q.frozen);

    // R5
    wait_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pending |-> !st_q.frozen && (st_q.drain != '0));

    // R8
    no_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pending && !sw_clear_i |=> !st_q.pending || (st_q.drain <= $past(st_q.drain)));
endmodule

// File: rtl/evt_err_ctrl.sv
`timescale 1ns/1ps
module evt_err_ctrl
    import eec_pkg::*;
#(
    parameter int KIND_W = 4,
    parameter int NSTR   = 8,
    parameter int CNT_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hit_eoe_i,
    input  logic                     road_eoe_i,
    input  logic                     evt_done_i,
    input  logic                     err_valid_i,
    input  logic [KIND_W-1:0]        err_kind_i,
    input  logic [NSTR-1:0]          err_streams_i,
    input  logic [(1<<KIND_W)-1:0]   sev_map_i,
    input  logic                     sw_clear_i,
    output logic                     init_evt_o,
    output logic                     freeze_bcast_o,
    output logic                     freeze_up_o,
    output logic [NSTR-1:0]          removed_o
);
    logic [CNT_W-1:0] open_cnt;
    err_act_e         act;
    logic             frozen;
    logic             pending;

    eec_boundary #(.CNT_W(CNT_W)) u_bnd (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_eoe_i  (hit_eoe_i),
        .road_eoe_i (road_eoe_i),
        .evt_done_i (evt_done_i),
        .init_o     (init_evt_o),
        .open_cnt_o (open_cnt)
    );

    eec_classify #(.KIND_W(KIND_W), .NSTR(NSTR)) u_cls (
        .clk           (clk),
        .rst_n         (rst_n),
        .err_valid_i   (err_valid_i),
        .err_kind_i    (err_kind_i),
        .err_streams_i (err_streams_i),
        .sev_map_i     (sev_map_i),
        .frozen_i      (frozen),
        .sw_clear_i    (sw_clear_i),
        .act_o         (act),
        .removed_o     (removed_o)
    );

    eec_freeze #(.CNT_W(CNT_W)) u_frz (
        .clk          (clk),
        .rst_n        (rst_n),
        .act_freeze_i (act == ACT_FREEZE),
        .open_cnt_i   (open_cnt),
        .evt_done_i   (evt_done_i),
        .sw_clear_i   (sw_clear_i),
        .frozen_o     (frozen),
        .pending_o    (pending)
    );

    assign freeze_bcast_o = frozen;
    assign freeze_up_o    = frozen;

    // R3
    freeze_no_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_FREEZE) |=> $stable(removed_o));

    // R7
    frozen_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frozen && !sw_clear_i |=> !pending);
endmodule

// File: tb/evt_err_ctrl_tb.sv
`timescale 1ns/1ps
module evt_err_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hit_eoe = 0, road_eoe = 0, evt_done = 0, err_valid = 0, sw_clear = 0;
    logic [3:0] err_kind = '0;
    logic [7:0] err_streams = '0;
    logic [15:0] sev_map = 16'h8100;
    logic       init_evt, frz_b, frz_u;
    logic [7:0] removed;

    int total = 0, bad = 0, init_cnt = 0;

    always #2.5 clk = ~clk;

    evt_err_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .hit_eoe_i(hit_eoe), .road_eoe_i(road_eoe),
        .evt_done_i(evt_done), .err_valid_i(err_valid), .err_kind_i(err_kind),
        .err_streams_i(err_streams), .sev_map_i(sev_map), .sw_clear_i(sw_clear),
        .init_evt_o(init_evt), .freeze_bcast_o(frz_b), .freeze_up_o(frz_u),
        .removed_o(removed)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference
    bit m_start, m_hs, m_rs, m_pend, m_frz, m_init, cmpl, old_pend, old_frz;
    int m_open, m_drn, dec, n;
    logic [7:0] m_rem;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_start = 1; m_hs = 0; m_rs = 0; m_pend = 0; m_frz = 0;
            m_init = 0; m_open = 0; m_drn = 0; m_rem = 0;
        end else begin
            cmpl = (m_hs || hit_eoe) && (m_rs || road_eoe);
            m_init = m_start || cmpl;
            m_start = 0;
            if (cmpl) begin m_hs = 0; m_rs = 0; end
            else begin m_hs = m_hs || hit_eoe; m_rs = m_rs || road_eoe; end
            dec = (evt_done && m_open > 0) ? 1 : 0;
            if (sw_clear) begin
                m_frz = 0; m_pend = 0; m_drn = 0; m_rem = 0;
            end else begin
                old_pend = m_pend; old_frz = m_frz;
                if (old_pend && dec == 1) begin
                    m_drn = m_drn - 1;
                    if (m_drn == 0) begin m_pend = 0; m_frz = 1; end
                end
                if (err_valid && !old_frz) begin
                    if (sev_map[err_kind]) begin
                        if (!old_pend) begin
                            n = m_open - dec;
                            if (n == 0) m_frz = 1;
                            else begin m_pend = 1; m_drn = n; end
                        end
                    end else begin
                        m_rem = m_rem | err_streams;
                    end
                end
            end
            m_open = m_open - dec + (m_init ? 1 : 0);
            if (m_open > 15) m_open = 15;
        end
        #1;
        if (init_evt) init_cnt++;
        chk(init_evt == m_init, "R2 init_evt_o", init_evt, m_init);
        chk(frz_b == m_frz, "R5 freeze_bcast_o", frz_b, m_frz);
        chk(frz_u == m_frz, "R6 freeze_up_o", frz_u, m_frz);
        chk(removed == m_rem, "R4 removed_o", removed, m_rem);
    end

    task automatic idle(input int cyc);
        repeat (cyc) @(negedge clk);
    endtask

    task automatic send_err(input logic [3:0] k, input logic [7:0] m);
        @(negedge clk);
        err_valid = 1; err_kind = k; err_streams = m;
        @(negedge clk);
        err_valid = 0; err_kind = '0; err_streams = '0;
    endtask

    task automatic send_done();
        @(negedge clk); evt_done = 1;
        @(negedge clk); evt_done = 0;
    endtask

    task automatic send_clear();
        @(negedge clk); sw_clear = 1;
        @(negedge clk); sw_clear = 0;
    endtask

    initial begin
        #250000;
        bad++; total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c0;
        idle(3);
        chk(frz_b == 0 && frz_u == 0 && removed == 0, "R1 reset state", removed, 0);
        rst_n = 1;
        @(negedge clk);
        chk(init_evt == 1, "R1 first init", init_evt, 1);
        @(negedge clk);
        chk(init_evt == 0, "R1 single pulse", init_evt, 0);

        // R2 orderings
        c0 = init_cnt;
        @(negedge clk); hit_eoe = 1; @(negedge clk); hit_eoe = 0;
        idle(2);
        chk(init_cnt == c0, "R2 hit alone", init_cnt - c0, 0);
        road_eoe = 1; @(negedge clk); road_eoe = 0;
        chk(init_evt == 1, "R2 hit then road", init_evt, 1);
        idle(2);
        @(negedge clk); road_eoe = 1; @(negedge clk); road_eoe = 0;
        idle(1);
        hit_eoe = 1; @(negedge clk); hit_eoe = 0;
        idle(1);
        hit_eoe = 1; road_eoe = 1; @(negedge clk); hit_eoe = 0; road_eoe = 0;
        idle(1);
        hit_eoe = 1; @(negedge clk); hit_eoe = 1; @(negedge clk); hit_eoe = 0;
        road_eoe = 1; @(negedge clk); road_eoe = 0;
        idle(2);
        chk(init_cnt == c0 + 4, "R2 pairing count", init_cnt - c0, 4);
        // five events open now

        // R4 removal
        send_err(4'd3, 8'h05);
        chk(removed == 8'h05, "R4 first removal", removed, 8'h05);
        send_err(4'd2, 8'h30);
        chk(removed == 8'h35, "R4 sticky or", removed, 8'h35);

        // R3 freeze error leaves mask alone, R5 wait for drain
        send_err(4'd8, 8'hFF);
        chk(removed == 8'h35 && frz_b == 0, "R3 freeze kind no mask", removed, 8'h35);
        send_done(); send_done();
        send_err(4'd15, 8'h00);           // R8 no restart
        send_err(4'd1, 8'h40);            // R8 removal during wait
        chk(removed == 8'h75, "R8 removal while waiting", removed, 8'h75);
        send_done(); send_done();
        chk(frz_b == 0, "R5 still draining", frz_b, 0);
        send_done();
        chk(frz_b == 1 && frz_u == 1, "R5 freeze after drain", frz_b, 1);

        // R7 ignored while frozen
        send_err(4'd0, 8'h80);
        chk(removed == 8'h75, "R7 mask unchanged", removed, 8'h75);
        idle(4);
        chk(frz_u == 1, "R6 freeze held", frz_u, 1);

        // R9 clear wins over same-cycle error
        @(negedge clk);
        sw_clear = 1; err_valid = 1; err_kind = 4'd4; err_streams = 8'h01;
        @(negedge clk);
        sw_clear = 0; err_valid = 0; err_kind = '0; err_streams = '0;
        chk(removed == 0 && frz_b == 0, "R9 clear", removed, 0);

        // R10 done with nothing open is ignored
        send_done(); send_done(); send_done();
        send_err(4'd8, 8'h00);
        chk(frz_b == 1, "R10 no open freezes at once", frz_b, 1);
        send_clear();
        chk(frz_b == 0, "R9 clear freeze", frz_b, 0);

        // R5 done in same cycle as error counts
        @(negedge clk); hit_eoe = 1; road_eoe = 1;
        @(negedge clk); hit_eoe = 0; road_eoe = 0;
        idle(1);
        evt_done = 1; err_valid = 1; err_kind = 4'd15;
        @(negedge clk);
        evt_done = 0; err_valid = 0; err_kind = '0;
        chk(frz_b == 1, "R5 same-cycle done", frz_b, 1);
        send_clear();

        // R10 saturation: 17 pairs, then drain 15
        for (int i = 0; i < 17; i++) begin
            @(negedge clk); hit_eoe = 1; road_eoe = 1;
            @(negedge clk); hit_eoe = 0; road_eoe = 0;
        end
        idle(1);
        send_err(4'd8, 8'h00);
        for (int i = 0; i < 14; i++) send_done();
        chk(frz_b == 0, "R10 saturated wait", frz_b, 0);
        send_done();
        chk(frz_b == 1, "R10 saturated drain", frz_b, 1);
        idle(3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule